// File: doc/BRIEF.md
# Double-Buffered Real-Time Clock Update Sequencer

This block keeps time of day as seconds, minutes and hours in two copies. An internal copy steps forward once per second and is never frozen. A user copy is what software reads. Once per second the block runs an update cycle. It raises an update-in-progress flag, waits a fixed number of fast timebase ticks, and then advances the internal copy. In the same clock edge it copies the new time into the user registers, compares the new time against three alarm bytes, and sets the update-ended flag. Software can therefore read a consistent time at any point of the second. A low update flag guarantees the full pre-update delay before the user bytes can change.

A freeze input stops all transfers into the user copy, so that software can read or rewrite the time without it moving underneath. The internal copy keeps counting through update cycles that still run every second. Time writes load both copies at once. A time written while frozen therefore becomes the base that the internal copy keeps advancing from, and it is shown by the first transfer after the freeze is released. A read strobe on the status register clears the update-ended and alarm flags. An interrupt output is high while a flag is set and its enable is set.

Top module: `rtc_update_seq`

## Requirements
- R1: After reset all user and alarm bytes are 0, and `uip`, `uf`, `af` and `irq` are low.
- R2: A one-cycle `tick_1hz` pulse with the update engine idle starts an update cycle. While `set_freeze` is low, `uip` is high from the next clock edge until the transfer.
- R3: The transfer happens on the clock edge of the PRE_TICKS-th `tick_fast` pulse after the start. `uip` falls on that edge, and the user time bytes do not change between the start and that edge. `tick_fast` pulses outside an update cycle have no effect.
- R4: Each update adds one second in binary. Seconds and minutes wrap from 59 to 0 with a carry, and hours wrap from 23 to 0.
- R5: While `set_freeze` is high, `uip` stays low and the user time bytes are not transferred. The internal copy still advances once per update cycle. The first transfer after `set_freeze` falls shows the accumulated time.
- R6: A write with `wr_sel` 0 (seconds), 1 (minutes) or 2 (hours) loads that field of both copies. The user byte shows the value after the next clock edge, and the write takes priority over an increment on the same edge.
- R7: `wr_sel` 3, 4 and 5 write the seconds, minutes and hours alarm bytes. At each transfer `af` is set when every alarm byte either equals the new time byte or has its two top bits both 1 (a wildcard). This also happens while frozen.
- R8: `uf` is set at the end of every update cycle, frozen or not.
- R9: A `stat_rd` pulse clears `uf` and `af`. A flag being set on the same edge wins over the clear.
- R10: `irq` is high exactly while (`uf` and `uf_ie`) or (`af` and `af_ie`).
- R11: A `tick_1hz` pulse that arrives while an update cycle is running is ignored. That cycle still ends with exactly one second added.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| tick_fast | input | 1 | One-cycle pulse of the fast timebase that paces the pre-update delay |
| set_freeze | input | 1 | Freezes the user copy and suppresses `uip` |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0..2 time, 3..5 alarm (sec, min, hr) |
| wr_data | input | DATA_W | Write data |
| stat_rd | input | 1 | Status read strobe; clears flags |
| uf_ie | input | 1 | Interrupt enable for the update-ended flag |
| af_ie | input | 1 | Interrupt enable for the alarm flag |
| uip | output | 1 | Update in progress |
| uf | output | 1 | Update-ended flag |
| af | output | 1 | Alarm flag |
| irq | output | 1 | Interrupt request |
| usr_sec | output | DATA_W | User seconds |
| usr_min | output | DATA_W | User minutes |
| usr_hr | output | DATA_W | User hours |

## Verification
The checker watches on every cycle the rules that tie ports together: `uip` is low under freeze, `uip` rises only after a second tick, and the user bytes hold except on a transfer or a write. It also checks that every finished update sets `uf`, that a status read clears the flags, and that the interrupt follows the flags. The arithmetic can only be shown by the bench's scenarios. This covers the carry chain and the 59/23 wraps, the time accumulated across a freeze, wildcard and mismatching alarms, and a second tick ignored in mid-cycle. All of these need known values written in and compared at the ports.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;
   localparam int NFIELDS = 3;

   // register select codes used on wr_sel
   typedef enum logic [2:0] {
      SEL_SEC  = 3'd0,
      SEL_MIN  = 3'd1,
      SEL_HR   = 3'd2,
      SEL_ASEC = 3'd3,
      SEL_AMIN = 3'd4,
      SEL_AHR  = 3'd5
   } reg_sel_e;

   // modulus of each time field, least significant field first
   function automatic int field_modulus(input int idx);
      return (idx == NFIELDS - 1) ? 24 : 60;
   endfunction
endpackage

// File: rtl/rtc_pre_timer.sv
module rtc_pre_timer #(
   parameter int PRE_TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick_fast,
   output logic busy,
   output logic done
);
   localparam int CW = (PRE_TICKS < 2) ? 1 : $clog2(PRE_TICKS);
   localparam logic [CW-1:0] LAST = CW'(PRE_TICKS - 1);

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   assign done = busy_q & tick_fast & (cnt_q == LAST);
   assign busy = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end
      end else if (tick_fast) begin
         if (cnt_q == LAST) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rtc_wrap_field.sv
module rtc_wrap_field #(
   parameter int DATA_W  = 8,
   parameter int MODULUS = 60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic              step,
   input  logic              carry_in,
   output logic [DATA_W-1:0] q,
   output logic [DATA_W-1:0] nxt,
   output logic              carry_out
);
   localparam logic [DATA_W-1:0] TOP = DATA_W'(MODULUS - 1);

   logic [DATA_W-1:0] q_r;
   logic              at_top;

   assign at_top    = (q_r == TOP);
   assign carry_out = carry_in & at_top;
   assign q         = q_r;

   always_comb begin
      nxt = q_r;
      if (carry_in) nxt = at_top ? '0 : q_r + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    q_r <= '0;
      else if (load) q_r <= load_val;
      else if (step) q_r <= nxt;
   end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
   parameter int DATA_W  = 8,
   parameter int NFIELDS = 3
) (
   input  logic [NFIELDS-1:0][DATA_W-1:0] time_v,
   input  logic [NFIELDS-1:0][DATA_W-1:0] alarm_v,
   output logic                           hit
);
   logic [NFIELDS-1:0] ok;

   for (genvar i = 0; i < NFIELDS; i++) begin : g_cmp
      logic wild;
      assign wild  = &alarm_v[i][DATA_W-1:DATA_W-2];
      assign ok[i] = wild | (alarm_v[i] == time_v[i]);
   end

   assign hit = &ok;
endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq
   import rtc_seq_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int PRE_TICKS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              tick_fast,
   input  logic              set_freeze,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              stat_rd,
   input  logic              uf_ie,
   input  logic              af_ie,
   output logic              uip,
   output logic              uf,
   output logic              af,
   output logic              irq,
   output logic [DATA_W-1:0] usr_sec,
   output logic [DATA_W-1:0] usr_min,
   output logic [DATA_W-1:0] usr_hr
);
   if (DATA_W < 6) begin : g_bad_width
      $error("rtc_update_seq: DATA_W must be at least 6");
   end
   if (PRE_TICKS < 1) begin : g_bad_delay
      $error("rtc_update_seq: PRE_TICKS must be at least 1");
   end

   logic upd_busy, upd_done, alarm_hit;
   logic [NFIELDS:0]              carry;
   logic [NFIELDS-1:0][DATA_W-1:0] int_q, nxt_q, usr_q, alm_q;
   logic uf_q, af_q;

   assign carry[0] = 1'b1;

   rtc_pre_timer #(.PRE_TICKS(PRE_TICKS)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (tick_1hz),
      .tick_fast (tick_fast),
      .busy      (upd_busy),
      .done      (upd_done)
   );

   for (genvar i = 0; i < NFIELDS; i++) begin : g_field
      logic wr_time, wr_alarm;
      assign wr_time  = wr_en && (wr_sel == 3'(i));
      assign wr_alarm = wr_en && (wr_sel == 3'(i + NFIELDS));

      rtc_wrap_field #(.DATA_W(DATA_W), .MODULUS(field_modulus(i))) u_int (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (wr_time),
         .load_val  (wr_data),
         .step      (upd_done),
         .carry_in  (carry[i]),
         .q         (int_q[i]),
         .nxt       (nxt_q[i]),
         .carry_out (carry[i+1])
      );

      always_ff @(posedge clk) begin
         if (!rst_n)                       usr_q[i] <= '0;
         else if (wr_time)                 usr_q[i] <= wr_data;
         else if (upd_done && !set_freeze) usr_q[i] <= nxt_q[i];
      end

      always_ff @(posedge clk) begin
         if (!rst_n)        alm_q[i] <= '0;
         else if (wr_alarm) alm_q[i] <= wr_data;
      end
   end

   rtc_alarm_match #(.DATA_W(DATA_W), .NFIELDS(NFIELDS)) u_alarm (
      .time_v  (nxt_q),
      .alarm_v (alm_q),
      .hit     (alarm_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         uf_q <= 1'b0;
         af_q <= 1'b0;
      end else begin
         if (upd_done)     uf_q <= 1'b1;
         else if (stat_rd) uf_q <= 1'b0;
         if (upd_done && alarm_hit) af_q <= 1'b1;
         else if (stat_rd)          af_q <= 1'b0;
      end
   end

   assign uip     = upd_busy & ~set_freeze;
   assign uf      = uf_q;
   assign af      = af_q;
   assign irq     = (uf_q & uf_ie) | (af_q & af_ie);
   assign usr_sec = usr_q[0];
   assign usr_min = usr_q[1];
   assign usr_hr  = usr_q[2];
endmodule

module rtc_update_seq_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_1hz,
   input logic              set_freeze,
   input logic              wr_en,
   input logic              stat_rd,
   input logic              uf_ie,
   input logic              uip,
   input logic              uf,
   input logic              af,
   input logic              irq,
   input logic              upd_done,
   input logic [DATA_W-1:0] usr_sec,
   input logic [DATA_W-1:0] usr_min,
   input logic [DATA_W-1:0] usr_hr
);
   p_uip_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(uip) && !$past(set_freeze)) |-> $past(tick_1hz));

   p_uip_falls_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_done && !set_freeze) |-> uip ##1 !uip);

   p_user_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !upd_done) |=> ($stable(usr_sec) && $stable(usr_min) && $stable(usr_hr)));

   p_frozen_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set_freeze |-> !uip);

   p_uf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      upd_done |=> uf);

   p_rd_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !upd_done) |=> (!uf && !af));

   p_irq_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!uf && !af) |-> !irq);

   p_irq_uf_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (uf && uf_ie) |-> irq);
endmodule

bind rtc_update_seq rtc_update_seq_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_rtc_update_seq.sv
module tb_rtc_update_seq;
   localparam int W   = 8;
   localparam int PRE = 8;

   logic clk = 1'b0;
   logic rst_n, tick_1hz, tick_fast, set_freeze, wr_en, stat_rd, uf_ie, af_ie;
   logic [2:0]   wr_sel;
   logic [W-1:0] wr_data;
   logic uip, uf, af, irq;
   logic [W-1:0] usr_sec, usr_min, usr_hr;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   rtc_update_seq #(.DATA_W(W), .PRE_TICKS(PRE)) dut (.*);

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_time(input string req, input int h, input int m, input int s);
      chk({req, " sec"}, usr_sec, s);
      chk({req, " min"}, usr_min, m);
      chk({req, " hr"},  usr_hr,  h);
   endtask

   task automatic wr(input int sel, input int val);
      wr_en = 1'b1; wr_sel = 3'(sel); wr_data = W'(val);
      cyc();
      wr_en = 1'b0;
   endtask

   task automatic set_time(input int h, input int m, input int s);
      wr(0, s); wr(1, m); wr(2, h);
   endtask

   task automatic status_read();
      stat_rd = 1'b1; cyc(); stat_rd = 1'b0;
   endtask

   task automatic start_upd();
      tick_1hz = 1'b1; cyc(); tick_1hz = 1'b0;
   endtask

   task automatic fast_ticks(input int n);
      for (int k = 0; k < n; k++) begin
         tick_fast = 1'b1; cyc(); tick_fast = 1'b0; cyc();
      end
   endtask

   task automatic full_update();
      start_upd();
      fast_ticks(PRE);
   endtask

   task automatic t_reset();
      chk("R1 sec", usr_sec, 0);
      chk("R1 min", usr_min, 0);
      chk("R1 hr", usr_hr, 0);
      chk("R1 uip", uip, 0);
      chk("R1 uf", uf, 0);
      chk("R1 af", af, 0);
      chk("R1 irq", irq, 0);
   endtask

   task automatic t_basic();
      set_time(3, 4, 5);
      chk_time("R6 write", 3, 4, 5);
      fast_ticks(3);
      chk("R3 idle fast tick", usr_sec, 5);
      start_upd();
      chk("R2 uip high", uip, 1);
      fast_ticks(PRE - 1);
      chk("R2 uip held", uip, 1);
      chk("R3 hold before transfer", usr_sec, 5);
      chk("R8 uf before end", uf, 0);
      fast_ticks(1);
      chk("R3 uip fall", uip, 0);
      chk_time("R4 step", 3, 4, 6);
      chk("R8 uf set", uf, 1);
      status_read();
   endtask

   task automatic t_wrap();
      set_time(23, 59, 59);
      full_update();
      chk_time("R4 full wrap", 0, 0, 0);
      set_time(7, 12, 59);
      full_update();
      chk_time("R4 minute carry", 7, 13, 0);
      status_read();
   endtask

   task automatic t_ignore_tick();
      set_time(1, 1, 10);
      start_upd();
      fast_ticks(3);
      start_upd();
      fast_ticks(PRE - 3);
      chk("R11 one step", usr_sec, 11);
      chk("R11 uip low", uip, 0);
      fast_ticks(PRE);
      chk("R11 no second step", usr_sec, 11);
      status_read();
   endtask

   task automatic t_freeze();
      set_time(10, 0, 5);
      set_freeze = 1'b1;
      cyc();
      start_upd();
      chk("R5 uip low frozen", uip, 0);
      fast_ticks(PRE);
      chk("R5 frozen sec", usr_sec, 5);
      chk("R8 uf while frozen", uf, 1);
      status_read();
      full_update();
      full_update();
      wr(0, 30);
      chk("R6 write while frozen", usr_sec, 30);
      full_update();
      chk("R5 still frozen", usr_sec, 30);
      set_freeze = 1'b0;
      cyc();
      chk("R5 no transfer yet", usr_sec, 30);
      full_update();
      chk_time("R5 accumulated", 10, 0, 32);
      status_read();
   endtask

   task automatic t_alarm();
      set_time(1, 2, 3);
      wr(3, 4); wr(4, 2); wr(5, 1);
      full_update();
      chk("R7 exact match", af, 1);
      status_read();
      chk("R9 af cleared", af, 0);
      chk("R9 uf cleared", uf, 0);
      full_update();
      chk("R7 mismatch", af, 0);
      wr(3, 8'hC0); wr(4, 8'hFF); wr(5, 9);
      full_update();
      chk("R7 hour mismatch", af, 0);
      wr(5, 1);
      full_update();
      chk("R7 wildcard match", af, 1);
      status_read();
      wr(3, 8'h80);
      full_update();
      chk("R7 one top bit no wildcard", af, 0);
      status_read();
   endtask

   task automatic t_irq();
      uf_ie = 1'b0; af_ie = 1'b0;
      wr(3, 8'hFF); wr(4, 8'hFF); wr(5, 8'hFF);
      full_update();
      chk("R10 disabled", irq, 0);
      uf_ie = 1'b1; cyc();
      chk("R10 uf enabled", irq, 1);
      uf_ie = 1'b0; af_ie = 1'b1; cyc();
      chk("R10 af enabled", irq, 1);
      status_read();
      chk("R10 after clear", irq, 0);
      start_upd();
      fast_ticks(PRE - 1);
      tick_fast = 1'b1; stat_rd = 1'b1;
      cyc();
      tick_fast = 1'b0; stat_rd = 1'b0;
      chk("R9 set wins uf", uf, 1);
      chk("R9 set wins af", af, 1);
      status_read();
      af_ie = 1'b0;
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      rst_n = 1'b0; tick_1hz = 1'b0; tick_fast = 1'b0; set_freeze = 1'b0;
      wr_en = 1'b0; wr_sel = '0; wr_data = '0; stat_rd = 1'b0;
      uf_ie = 1'b0; af_ie = 1'b0;
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      t_reset();
      t_basic();
      t_wrap();
      t_ignore_tick();
      t_freeze();
      t_alarm();
      t_irq();
      report();
   end
endmodule